// File: doc/BRIEF.md
# Stream-to-Memory Burst Writer

This block takes a stream of data words and stores them at consecutive memory addresses. It writes them through a memory-mapped master port using incrementing AXI4 write bursts. Software programs a byte start address and a word count through a small AXI-Lite register port, then sets a start bit. The block accepts exactly that many stream words into an internal FIFO. It then writes them out in bursts of up to sixteen beats and reports completion only after every burst has been acknowledged.

Three rules keep the memory side well behaved:
- A burst address is requested only when the FIFO already holds every word of that burst, so the write data never waits on the stream.
- A burst is cut short so that it never runs past a 4 KB page.
- Once an address request is raised, it stays unchanged until the memory side accepts it.

Any error response from memory is latched as a sticky flag that software can read.

Top module: `strm_mem_writer`

## Requirements
- R1: After reset all three registers read 0, the stream ready, the burst address valid and the burst data valid are low, and the register port has no pending response.
- R2: The register map uses word offsets. Offset 0x0 is control/status: a write with bit 0 set is a start command; a read returns busy in bit 0 and error in bit 1. Offset 0x4 holds the byte start address, which must be word aligned. Offset 0x8 holds the length in words. Register writes and reads answer with response code 0 (OKAY).
- R3: Stream ready is low whenever the FIFO holds DEPTH words, whenever the block is idle, and once the programmed number of words has been accepted. Exactly the programmed number of words is taken per job.
- R4: A burst address request appears only when the FIFO holds at least AWLEN+1 words not yet written out, so the FIFO is never read while empty.
- R5: Each burst has length min(16, words not yet requested, words left before the next 4 KB boundary). Bursts cover consecutive addresses from the start address. AWSIZE is log2 of the bytes per word and AWBURST is 2'b01 (incrementing).
- R6: While the burst address valid is high and not yet accepted, it stays high and the address and length do not change.
- R7: No burst crosses a 4 KB address boundary.
- R8: Each burst carries exactly AWLEN+1 data beats, WLAST is high on the final beat only, and WSTRB is all ones. The data are the stream words in arrival order.
- R9: Busy stays set until every issued burst has received its write response, even after all data beats have been sent.
- R10: A write response other than 0 sets the error bit. The bit stays set after the job ends and clears only on the next accepted start.
- R11: A start command written while busy is ignored, and so is a start with length 0. Neither launches any burst nor accepts any stream word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_awvalid | input | 1 | Register write address valid |
| cfg_awready | output | 1 | Register write address ready |
| cfg_awaddr | input | 4 | Register write byte offset |
| cfg_wvalid | input | 1 | Register write data valid |
| cfg_wready | output | 1 | Register write data ready |
| cfg_wdata | input | 32 | Register write data |
| cfg_bvalid | output | 1 | Register write response valid |
| cfg_bready | input | 1 | Register write response ready |
| cfg_bresp | output | 2 | Register write response code |
| cfg_arvalid | input | 1 | Register read address valid |
| cfg_arready | output | 1 | Register read address ready |
| cfg_araddr | input | 4 | Register read byte offset |
| cfg_rvalid | output | 1 | Register read data valid |
| cfg_rready | input | 1 | Register read data ready |
| cfg_rdata | output | 32 | Register read data |
| cfg_rresp | output | 2 | Register read response code |
| s_tvalid | input | 1 | Stream word valid |
| s_tready | output | 1 | Stream word ready |
| s_tdata | input | DW | Stream word |
| m_awvalid | output | 1 | Burst address valid |
| m_awready | input | 1 | Burst address ready |
| m_awaddr | output | 32 | Burst byte address |
| m_awlen | output | 8 | Burst beats minus one |
| m_awsize | output | 3 | log2 bytes per beat |
| m_awburst | output | 2 | Burst type (incrementing) |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | DW | Write data |
| m_wstrb | output | DW/8 | Write byte strobes |
| m_wlast | output | 1 | Final beat of burst |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response code |

## Verification
Burst address, data and stream results appear as handshakes, so the bench checks each one at the falling edge that comes before the rising edge where it completes. Each handshake is compared with the expected address, length or word for that position in the job, without counting a fixed latency. Status reads come back on the register port one cycle after the read address is accepted, and the bench polls busy rather than predicting the cycle in which it falls. For the response-wait case, the bench holds responses back until all data beats have been counted, then reads status and expects busy still set. The FIFO-full case slows the data side until the bench's own count of buffered words reaches the depth, and then expects stream ready low in that same sampled cycle.

// File: rtl/strm_mem_writer_pkg.sv
// Package: shared constants and types for the stream-to-memory writer.
// Assumes 32-bit memory addresses and 4 KB pages.
package strm_mem_writer_pkg;
    localparam int ADDR_W    = 32;
    localparam int CFG_W     = 32;
    localparam int PAGE_BITS = 12;
    localparam logic [1:0] RESP_OKAY = 2'b00;
    localparam logic [1:0] BURST_INCR = 2'b01;

    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_ADDR = 4'h4;
    localparam logic [3:0] OFS_LEN  = 4'h8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_DATA
    } wr_state_t;
endpackage

// File: rtl/strm_fifo.sv
// Module: show-ahead FIFO holding captured stream words.
// Assumes DEPTH is a power of two; the caller never pushes when full
// and never pops when empty (both checked below).
module strm_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    // Storage write; no reset needed for data words.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign head = mem[rd_ptr];
    assign full = (count == CW'(DEPTH));

    AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0)); // R4
    AST_NO_FULL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count != CW'(DEPTH))); // R3
endmodule

// File: rtl/strm_cfg_regs.sv
// Module: AXI-Lite register slave holding start address and length,
// issuing a one-cycle start pulse and reporting busy/error.
// Assumes one outstanding write and one outstanding read at a time.
module strm_cfg_regs
    import strm_mem_writer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_awvalid,
    output logic              cfg_awready,
    input  logic [3:0]        cfg_awaddr,
    input  logic              cfg_wvalid,
    output logic              cfg_wready,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic              cfg_bvalid,
    input  logic              cfg_bready,
    output logic [1:0]        cfg_bresp,
    input  logic              cfg_arvalid,
    output logic              cfg_arready,
    input  logic [3:0]        cfg_araddr,
    output logic              cfg_rvalid,
    input  logic              cfg_rready,
    output logic [CFG_W-1:0]  cfg_rdata,
    output logic [1:0]        cfg_rresp,
    input  logic              busy,
    input  logic              err,
    output logic              start,
    output logic [ADDR_W-1:0] job_addr,
    output logic [CFG_W-1:0]  job_len
);
    logic wr_take, rd_take;

    assign wr_take     = cfg_awvalid && cfg_wvalid && !cfg_bvalid;
    assign cfg_awready = wr_take;
    assign cfg_wready  = wr_take;
    assign rd_take     = cfg_arvalid && !cfg_rvalid;
    assign cfg_arready = rd_take;
    assign cfg_bresp   = RESP_OKAY;
    assign cfg_rresp   = RESP_OKAY;
    assign start       = wr_take && (cfg_awaddr == OFS_CTRL) && cfg_wdata[0];

    // Register writes and write-response handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            job_addr   <= '0;
            job_len    <= '0;
            cfg_bvalid <= 1'b0;
        end else begin
            if (wr_take) begin
                cfg_bvalid <= 1'b1;
                if (cfg_awaddr == OFS_ADDR) job_addr <= cfg_wdata;
                if (cfg_awaddr == OFS_LEN)  job_len  <= cfg_wdata;
            end else if (cfg_bready) begin
                cfg_bvalid <= 1'b0;
            end
        end
    end

    // Register reads and read-response handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rvalid <= 1'b0;
            cfg_rdata  <= '0;
        end else begin
            if (rd_take) begin
                cfg_rvalid <= 1'b1;
                case (cfg_araddr)
                    OFS_CTRL: cfg_rdata <= {{(CFG_W-2){1'b0}}, err, busy};
                    OFS_ADDR: cfg_rdata <= job_addr;
                    OFS_LEN:  cfg_rdata <= job_len;
                    default:  cfg_rdata <= '0;
                endcase
            end else if (cfg_rready) begin
                cfg_rvalid <= 1'b0;
            end
        end
    end

    AST_ONE_WRITE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bvalid && !cfg_bready) |=> cfg_bvalid); // R2
endmodule

// File: rtl/strm_burst_engine.sv
// Module: sizes and issues write bursts from the FIFO, tracks outstanding
// responses, owns busy/error and stream acceptance.
// Assumes the start address is word aligned and memory replies once per burst.
module strm_burst_engine
    import strm_mem_writer_pkg::*;
#(
    parameter int DW        = 32,
    parameter int MAX_BEATS = 16,
    parameter int FCW       = 6,
    localparam int BPW      = DW / 8,
    localparam int BSH      = $clog2(BPW),
    localparam int PG_WORDS = (1 << PAGE_BITS) / BPW,
    localparam int OW       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] job_addr,
    input  logic [CFG_W-1:0]  job_len,
    output logic              busy,
    output logic              err,
    input  logic [FCW-1:0]    fifo_cnt,
    input  logic              fifo_full,
    output logic              fifo_pop,
    input  logic              s_tvalid,
    output logic              s_tready,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [ADDR_W-1:0] m_awaddr,
    output logic [7:0]        m_awlen,
    output logic              m_wvalid,
    input  logic              m_wready,
    output logic              m_wlast,
    input  logic              m_bvalid,
    output logic              m_bready,
    input  logic [1:0]        m_bresp
);
    wr_state_t         state;
    logic [ADDR_W-1:0] cur_addr;
    logic [CFG_W-1:0]  issue_left, take_left;
    logic [CFG_W-1:0]  page_left, cap16, blen;
    logic [7:0]        beat;
    logic [OW-1:0]     outst;
    logic              aw_hs, b_hs, go;

    assign page_left = CFG_W'(PG_WORDS) -
                       {{(CFG_W-PAGE_BITS+BSH){1'b0}}, cur_addr[PAGE_BITS-1:BSH]};
    assign cap16 = (issue_left < CFG_W'(MAX_BEATS)) ? issue_left : CFG_W'(MAX_BEATS);
    assign blen  = (page_left < cap16) ? page_left : cap16;
    assign go    = (state == ST_IDLE) && busy && (issue_left != '0) &&
                   ({{(CFG_W-FCW){1'b0}}, fifo_cnt} >= blen);

    assign m_awvalid = (state == ST_REQ);
    assign m_wvalid  = (state == ST_DATA);
    assign m_wlast   = m_wvalid && (beat == m_awlen);
    assign fifo_pop  = m_wvalid && m_wready;
    assign m_bready  = 1'b1;
    assign aw_hs     = m_awvalid && m_awready;
    assign b_hs      = m_bvalid && m_bready;
    assign s_tready  = busy && (take_left != '0) && !fifo_full;

    // Burst sequencing: wait for data, request address, stream beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cur_addr   <= '0;
            issue_left <= '0;
            m_awaddr   <= '0;
            m_awlen    <= '0;
            beat       <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start && !busy) begin
                        cur_addr   <= job_addr;
                        issue_left <= job_len;
                    end else if (go) begin
                        m_awaddr <= cur_addr;
                        m_awlen  <= blen[7:0] - 8'd1;
                        state    <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (m_awready) begin
                        cur_addr   <= cur_addr + ((ADDR_W'(m_awlen) + 1) << BSH);
                        issue_left <= issue_left - (CFG_W'(m_awlen) + 1);
                        beat       <= '0;
                        state      <= ST_DATA;
                    end
                end
                default: begin
                    if (m_wready) begin
                        beat <= beat + 8'd1;
                        if (m_wlast) state <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // Job status: busy, sticky error, outstanding responses, words to take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            err       <= 1'b0;
            outst     <= '0;
            take_left <= '0;
        end else begin
            outst <= outst + OW'(aw_hs) - OW'(b_hs);
            if (s_tvalid && s_tready) take_left <= take_left - 1'b1;
            if (b_hs && (m_bresp != RESP_OKAY)) err <= 1'b1;
            if (start && !busy && (job_len != '0)) begin
                busy      <= 1'b1;
                err       <= 1'b0;
                take_left <= job_len;
            end else if (busy && (issue_left == '0) && (outst == '0) &&
                         (state == ST_IDLE)) begin
                busy <= 1'b0;
            end
        end
    end

    AST_AW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr) && $stable(m_awlen))); // R6
    AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> ((({1'b0, m_awaddr[PAGE_BITS-1:0]}) +
                        ((13'(m_awlen) + 13'd1) << BSH)) <= 13'(1 << PAGE_BITS))); // R7
    AST_BURST_FED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_awvalid) |-> (9'(fifo_cnt) >= (9'(m_awlen) + 9'd1))); // R4
    AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> (m_awlen < 8'(MAX_BEATS))); // R5
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (outst != '0) |-> busy); // R9
endmodule

// File: rtl/strm_mem_writer.sv
// Module: top level of the stream-to-memory burst writer. Connects the
// register slave, the capture FIFO and the burst engine.
// Assumes DEPTH >= MAX_BEATS so a full burst always fits in the FIFO.
module strm_mem_writer
    import strm_mem_writer_pkg::*;
#(
    parameter int DW        = 32,
    parameter int DEPTH     = 32,
    parameter int MAX_BEATS = 16,
    localparam int FCW      = $clog2(DEPTH) + 1,
    localparam int SW       = DW / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_awvalid,
    output logic              cfg_awready,
    input  logic [3:0]        cfg_awaddr,
    input  logic              cfg_wvalid,
    output logic              cfg_wready,
    input  logic [31:0]       cfg_wdata,
    output logic              cfg_bvalid,
    input  logic              cfg_bready,
    output logic [1:0]        cfg_bresp,
    input  logic              cfg_arvalid,
    output logic              cfg_arready,
    input  logic [3:0]        cfg_araddr,
    output logic              cfg_rvalid,
    input  logic              cfg_rready,
    output logic [31:0]       cfg_rdata,
    output logic [1:0]        cfg_rresp,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic [DW-1:0]     s_tdata,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [31:0]       m_awaddr,
    output logic [7:0]        m_awlen,
    output logic [2:0]        m_awsize,
    output logic [1:0]        m_awburst,
    output logic              m_wvalid,
    input  logic              m_wready,
    output logic [DW-1:0]     m_wdata,
    output logic [SW-1:0]     m_wstrb,
    output logic              m_wlast,
    input  logic              m_bvalid,
    output logic              m_bready,
    input  logic [1:0]        m_bresp
);
    logic              start, busy, err, pop, full;
    logic [ADDR_W-1:0] job_addr;
    logic [CFG_W-1:0]  job_len;
    logic [FCW-1:0]    fcnt;

    assign m_awsize  = 3'($clog2(SW));
    assign m_awburst = BURST_INCR;
    assign m_wstrb   = '1;

    strm_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_awvalid(cfg_awvalid), .cfg_awready(cfg_awready), .cfg_awaddr(cfg_awaddr),
        .cfg_wvalid(cfg_wvalid), .cfg_wready(cfg_wready), .cfg_wdata(cfg_wdata),
        .cfg_bvalid(cfg_bvalid), .cfg_bready(cfg_bready), .cfg_bresp(cfg_bresp),
        .cfg_arvalid(cfg_arvalid), .cfg_arready(cfg_arready), .cfg_araddr(cfg_araddr),
        .cfg_rvalid(cfg_rvalid), .cfg_rready(cfg_rready), .cfg_rdata(cfg_rdata),
        .cfg_rresp(cfg_rresp),
        .busy(busy), .err(err), .start(start), .job_addr(job_addr), .job_len(job_len)
    );

    strm_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(s_tvalid && s_tready), .push_data(s_tdata),
        .pop(pop), .head(m_wdata), .count(fcnt), .full(full)
    );

    strm_burst_engine #(.DW(DW), .MAX_BEATS(MAX_BEATS), .FCW(FCW)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .start(start), .job_addr(job_addr), .job_len(job_len),
        .busy(busy), .err(err),
        .fifo_cnt(fcnt), .fifo_full(full), .fifo_pop(pop),
        .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_awaddr(m_awaddr), .m_awlen(m_awlen),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wlast(m_wlast),
        .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp)
    );
endmodule

// File: tb/strm_mem_writer_tb.sv
module strm_mem_writer_tb;
    localparam int DEPTH = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic cfg_awvalid = 0, cfg_wvalid = 0, cfg_arvalid = 0;
    logic cfg_awready, cfg_wready, cfg_bvalid, cfg_arready, cfg_rvalid;
    logic [3:0] cfg_awaddr = 0, cfg_araddr = 0;
    logic [31:0] cfg_wdata = 0, cfg_rdata;
    logic [1:0] cfg_bresp, cfg_rresp;
    logic s_tvalid = 0, s_tready;
    logic [31:0] s_tdata = 0;
    logic m_awvalid, m_awready = 0, m_wvalid, m_wready = 0, m_wlast;
    logic [31:0] m_awaddr, m_wdata;
    logic [7:0] m_awlen;
    logic [2:0] m_awsize;
    logic [1:0] m_awburst, m_bresp = 0;
    logic [3:0] m_wstrb;
    logic m_bvalid = 0, m_bready;

    strm_mem_writer u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_awvalid(cfg_awvalid), .cfg_awready(cfg_awready), .cfg_awaddr(cfg_awaddr),
        .cfg_wvalid(cfg_wvalid), .cfg_wready(cfg_wready), .cfg_wdata(cfg_wdata),
        .cfg_bvalid(cfg_bvalid), .cfg_bready(1'b1), .cfg_bresp(cfg_bresp),
        .cfg_arvalid(cfg_arvalid), .cfg_arready(cfg_arready), .cfg_araddr(cfg_araddr),
        .cfg_rvalid(cfg_rvalid), .cfg_rready(1'b1), .cfg_rdata(cfg_rdata), .cfg_rresp(cfg_rresp),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
        .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata),
        .m_wstrb(m_wstrb), .m_wlast(m_wlast),
        .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp)
    );

    int n_chk = 0, n_bad = 0;
    bit reported = 0;

    // Model state shared between the test sequence and the bus loop.
    int job_len = 0, tidx = 0, cap_cnt = 0, wr_cnt = 0, exp_left = 0;
    int beat = 0, cur_len = 0, pend_b = 0, max_lvl = 0, aw_cnt = 0;
    logic [31:0] exp_addr = 0, jseed = 0;
    bit hold_b = 0, err_mode = 0, slow_w = 0;
    bit prev_wait = 0;
    logic [31:0] prev_addr = 0;
    logic [7:0] prev_len = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
        $finish;
    endtask

    function automatic logic [31:0] pat(input int i);
        return jseed ^ (32'(i) * 32'h9E37_79B9) ^ 32'(i);
    endfunction

    function automatic int exp_blen(input logic [31:0] a, input int left);
        int pl = (4096 - int'(a % 4096)) / 4;
        int m = (left < 16) ? left : 16;
        return (pl < m) ? pl : m;
    endfunction

    // Bus model: monitor at falling edge, drive just after rising edge.
    initial begin
        forever begin
            bit aw_hs, w_hs, b_hs, t_hs;
            @(negedge clk);
            aw_hs = m_awvalid && m_awready;
            w_hs  = m_wvalid && m_wready;
            b_hs  = m_bvalid && m_bready;
            t_hs  = s_tvalid && s_tready;
            if (rst_n) begin
                if (prev_wait)
                    chk(m_awvalid && m_awaddr == prev_addr && m_awlen == prev_len,
                        "R6", "held request", m_awaddr, prev_addr);
                prev_wait = m_awvalid && !m_awready;
                prev_addr = m_awaddr;
                prev_len  = m_awlen;
                if (cap_cnt - wr_cnt > max_lvl) max_lvl = cap_cnt - wr_cnt;
                if (cap_cnt - wr_cnt >= DEPTH)
                    chk(!s_tready, "R3", "ready while full", 32'(s_tready), 0);
                if (cap_cnt >= job_len)
                    chk(!s_tready, "R3", "ready after length", 32'(s_tready), 0);
                if (aw_hs) begin
                    int el;
                    aw_cnt++;
                    chk(exp_left > 0, "R11", "unexpected burst", m_awaddr, 0);
                    el = exp_blen(exp_addr, exp_left);
                    chk(m_awaddr == exp_addr, "R5", "burst address", m_awaddr, exp_addr);
                    chk(int'(m_awlen) + 1 == el, "R5", "burst length", 32'(m_awlen) + 1, 32'(el));
                    chk(m_awsize == 3'd2 && m_awburst == 2'b01, "R5", "size/type",
                        {m_awsize, m_awburst}, {3'd2, 2'b01});
                    chk((m_awaddr % 4096) + (32'(m_awlen) + 1) * 4 <= 4096, "R7",
                        "page crossing", m_awaddr, 32'(m_awlen));
                    chk(cap_cnt - wr_cnt >= int'(m_awlen) + 1, "R4", "buffered words",
                        32'(cap_cnt - wr_cnt), 32'(m_awlen) + 1);
                    cur_len  = int'(m_awlen) + 1;
                    beat     = 0;
                    exp_addr = exp_addr + 32'(cur_len * 4);
                    exp_left = exp_left - cur_len;
                end
                if (w_hs) begin
                    chk(m_wdata == pat(wr_cnt), "R8", "beat data", m_wdata, pat(wr_cnt));
                    chk(m_wlast == (beat == cur_len - 1), "R8", "last flag",
                        32'(m_wlast), 32'(beat == cur_len - 1));
                    chk(m_wstrb == 4'hF, "R8", "strobes", 32'(m_wstrb), 32'hF);
                    beat++;
                    wr_cnt++;
                    if (m_wlast) pend_b++;
                end
                if (t_hs) begin
                    cap_cnt++;
                    tidx++;
                end
                if (b_hs) ;
            end
            @(posedge clk);
            #1;
            m_awready = ($urandom % 4) != 0;
            m_wready  = slow_w ? (($urandom % 8) == 0) : (($urandom % 3) != 0);
            if (!(s_tvalid && !t_hs)) begin
                s_tvalid = (tidx < job_len) && (($urandom % 4) != 0);
                s_tdata  = pat(tidx);
            end
            if (!(m_bvalid && !b_hs)) begin
                if (pend_b > 0 && !hold_b && ($urandom % 2) == 1) begin
                    m_bvalid = 1;
                    m_bresp  = err_mode ? 2'b10 : 2'b00;
                    pend_b--;
                end else begin
                    m_bvalid = 0;
                end
            end
        end
    end

    task automatic lite_write(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        cfg_awaddr = a; cfg_wdata = d; cfg_awvalid = 1; cfg_wvalid = 1;
        do @(negedge clk); while (!cfg_awready);
        @(posedge clk); #1;
        cfg_awvalid = 0; cfg_wvalid = 0;
        @(negedge clk);
        chk(cfg_bvalid && cfg_bresp == 2'b00, "R2", "write response", 32'(cfg_bresp), 0);
    endtask

    task automatic lite_read(input logic [3:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        cfg_araddr = a; cfg_arvalid = 1;
        do @(negedge clk); while (!cfg_arready);
        @(posedge clk); #1;
        cfg_arvalid = 0;
        @(negedge clk);
        chk(cfg_rvalid && cfg_rresp == 2'b00, "R2", "read response", 32'(cfg_rresp), 0);
        d = cfg_rdata;
    endtask

    task automatic setup_job(input logic [31:0] a, input int n);
        @(posedge clk); #1;
        jseed = $urandom; job_len = n; tidx = 0; cap_cnt = 0; wr_cnt = 0;
        exp_addr = a; exp_left = n; max_lvl = 0; aw_cnt = 0;
        lite_write(4'h4, a);
        lite_write(4'h8, 32'(n));
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] st;
        int tries = 0;
        do begin
            lite_read(4'h0, st);
            tries++;
        end while (st[0] && tries < 4000);
        chk(!st[0], req, "busy never cleared", st, 0);
    endtask

    task automatic end_checks(input string tag);
        chk(wr_cnt == job_len, "R8", {tag, " beats written"}, 32'(wr_cnt), 32'(job_len));
        chk(cap_cnt == job_len, "R3", {tag, " words taken"}, 32'(cap_cnt), 32'(job_len));
        chk(exp_left == 0, "R5", {tag, " words requested"}, 32'(exp_left), 0);
    endtask

    task automatic run_job(input logic [31:0] a, input int n, input string tag);
        setup_job(a, n);
        lite_write(4'h0, 32'h1);
        wait_idle("R9");
        end_checks(tag);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd20240611));
        repeat (5) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1: reset state at the ports
        chk(!s_tready && !m_awvalid && !m_wvalid, "R1", "idle outputs",
            {29'd0, s_tready, m_awvalid, m_wvalid}, 0);
        chk(!cfg_bvalid && !cfg_rvalid, "R1", "no pending response",
            {30'd0, cfg_bvalid, cfg_rvalid}, 0);
        lite_read(4'h0, rd); chk(rd == 0, "R1", "status reset", rd, 0);
        lite_read(4'h4, rd); chk(rd == 0, "R1", "address reset", rd, 0);
        lite_read(4'h8, rd); chk(rd == 0, "R1", "length reset", rd, 0);

        // R2: register readback
        lite_write(4'h4, 32'h0001_2340);
        lite_write(4'h8, 32'd77);
        lite_read(4'h4, rd); chk(rd == 32'h0001_2340, "R2", "address readback", rd, 32'h0001_2340);
        lite_read(4'h8, rd); chk(rd == 32'd77, "R2", "length readback", rd, 77);

        // R3: slow write side fills the FIFO; 40 words -> 16,16,8
        slow_w = 1;
        run_job(32'h0000_1000, 40, "fill");
        chk(max_lvl == DEPTH, "R3", "FIFO reached depth", 32'(max_lvl), DEPTH);
        chk(aw_cnt == 3, "R5", "burst count 16/16/8", 32'(aw_cnt), 3);
        slow_w = 0;

        // R7: start 8 words below a page boundary -> bursts 8, 12
        run_job(32'h0000_0FE0, 20, "page");
        chk(aw_cnt == 2, "R7", "page split count", 32'(aw_cnt), 2);

        // R9: hold responses; busy stays set after all beats sent
        hold_b = 1;
        setup_job(32'h0000_0200, 20);
        lite_write(4'h0, 32'h1);
        while (wr_cnt < 20) @(posedge clk);
        repeat (10) @(posedge clk);
        lite_read(4'h0, rd);
        chk(rd[0] == 1'b1, "R9", "busy while responses pending", rd, 1);
        hold_b = 0;
        wait_idle("R9");
        end_checks("hold");

        // R10: error response is sticky, cleared by next start
        err_mode = 1;
        run_job(32'h0000_3000, 18, "err");
        err_mode = 0;
        lite_read(4'h0, rd);
        chk(rd[1:0] == 2'b10, "R10", "error kept after job", rd, 2);
        setup_job(32'h0000_4000, 5);
        lite_write(4'h0, 32'h1);
        lite_read(4'h0, rd);
        chk(rd[1] == 1'b0, "R10", "error cleared on start", rd, 0);
        wait_idle("R10");
        end_checks("clear");

        // R11: start while busy, and start with length zero
        setup_job(32'h0000_5000, 40);
        lite_write(4'h0, 32'h1);
        lite_write(4'h4, 32'h0000_9000);
        lite_write(4'h8, 32'd7);
        lite_write(4'h0, 32'h1);
        wait_idle("R11");
        end_checks("restart");
        chk(aw_cnt == 3, "R11", "no extra bursts", 32'(aw_cnt), 3);
        repeat (20) @(posedge clk);
        lite_read(4'h0, rd);
        chk(rd[0] == 1'b0, "R11", "not restarted", rd, 0);
        setup_job(32'h0000_6000, 0);
        lite_write(4'h0, 32'h1);
        lite_read(4'h0, rd);
        chk(rd[0] == 1'b0, "R11", "zero length ignored", rd, 0);
        repeat (20) @(posedge clk);
        chk(aw_cnt == 0, "R11", "no burst for zero length", 32'(aw_cnt), 0);

        // Random jobs
        for (int j = 0; j < 8; j++) begin
            logic [31:0] a = ($urandom % 16384) * 4;
            int n = 1 + int'($urandom % 70);
            run_job(a, n, "random");
        end
        report();
    end
endmodule